// File: doc/BRIEF.md
# Indexed CMOS Register File

This block is a 128-byte non-volatile-style byte store reached through a two-location byte port. A write to the even location picks which byte is addressed. A read or write at the odd location then reaches that byte. Four bytes near the bottom of the map follow their own rules. The control byte at index 10 has a busy bit in bit 7 that the port cannot change. The flag byte at index 12 and the status byte at index 13 ignore port writes. The flag byte also empties itself when it is read, and that read lowers the interrupt line.

A second write-only port is used by the host platform. It writes any byte without the per-index rules. When it writes a byte inside the configuration window 0x10..0x2D, a small sequencer sums the window one byte per clock. It then stores the 16-bit result, high byte at 0x2E and low byte at 0x2F. Time keeping and interrupt sources are separate blocks. They set flag bits through an event input, and they set or clear the busy bit through two strobes.

Top module: `cmos_regfile`

## Requirements
- R1: A port write with `bus_sel`=0 stores `bus_wdata[6:0]` as the current index and drops bit 7. The index is 0 after reset.
- R2: With `bus_sel`=0, `bus_rdata` reads 0xFF. With `bus_sel`=1, it shows the byte at the current index in the same cycle.
- R3: Port writes to index 12 (flags) and index 13 (status) change nothing.
- R4: A port write to index 10 takes data bits 6:0 and keeps the existing bit 7 (busy).
- R5: A port read of index 12 returns the flags, then clears them to 0x00 and drops `irq`. Event bits that arrive in the same cycle as that read are kept.
- R6: A port write to index 11 with bit 7 (freeze) high clears bit 7 of index 10. `uip_set` is ignored while index 11 bit 7 is high.
- R7: After a host write, index 0x2E holds the high byte and index 0x2F the low byte of the 16-bit sum of bytes 0x10..0x2D.
- R8: `cks_busy` rises in the cycle after a host write into 0x10..0x2D and stays high for 31 cycles. A host write during a recomputation restarts it. Port writes, and host writes outside the window, start nothing.
- R9: Reset gives index 10 = 0x26, index 11 = 0x02, index 12 = 0x00, index 13 = 0x80, and 0x00 in every other byte.
- R10: A nonzero `evt_flags` is ORed into index 12 and raises `irq`. `irq` stays high until index 12 is read.
- R11: A port write to any index other than 10..13 stores the whole byte. A host write stores its byte unchanged at any index.
- R12: `uip_set` sets and `uip_clr` clears bit 7 of index 10. If both are high, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | 0 = index location, 1 = data location |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe (read side effects) |
| bus_wdata | input | 8 | Port write data |
| bus_rdata | output | 8 | Port read data |
| host_wr | input | 1 | Host write strobe |
| host_idx | input | 7 | Host write index |
| host_wdata | input | 8 | Host write data |
| evt_flags | input | 8 | Flag bits to set in index 12 |
| uip_set | input | 1 | Set busy bit of index 10 |
| uip_clr | input | 1 | Clear busy bit of index 10 |
| irq | output | 1 | Level interrupt, high while flags are unread |
| cks_busy | output | 1 | Checksum recomputation running |

## Verification
The index path is swept over all 256 values of the written byte. Each value is read back against a distinct per-index fill, so a kept bit 7 or a wrong special-index rule shows up as a mismatch. The checksum is driven with all-ones, all-zeros and an XOR pattern. These separate a truncated sum, swapped result bytes and a wrong window edge. A restart mid-run and window-miss writes show whether the busy window is measured from the last trigger only. The flag tests put an event in the same cycle as the clearing read, which shows whether set wins over clear.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;
  localparam int SUM_W  = 16;
  localparam int NREG   = 1 << IDX_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [SUM_W-1:0]  sum_t;

  localparam idx_t IX_CTRL_A = 7'd10;
  localparam idx_t IX_CTRL_B = 7'd11;
  localparam idx_t IX_FLAGS  = 7'd12;
  localparam idx_t IX_STAT   = 7'd13;

  localparam int BUSY_BIT   = 7;
  localparam int FREEZE_BIT = 7;

  localparam byte_t RST_CTRL_A = 8'h26;
  localparam byte_t RST_CTRL_B = 8'h02;
  localparam byte_t RST_FLAGS  = 8'h00;
  localparam byte_t RST_STAT   = 8'h80;

  function automatic byte_t reset_value(idx_t i);
    case (i)
      IX_CTRL_A: return RST_CTRL_A;
      IX_CTRL_B: return RST_CTRL_B;
      IX_FLAGS:  return RST_FLAGS;
      IX_STAT:   return RST_STAT;
      default:   return '0;
    endcase
  endfunction

  function automatic sum_t sum_step(sum_t acc, byte_t b);
    return acc + {{(SUM_W-DATA_W){1'b0}}, b};
  endfunction

  function automatic byte_t ctrl_a_merge(byte_t old_v, byte_t new_v);
    byte_t r;
    r = new_v;
    r[BUSY_BIT] = old_v[BUSY_BIT];
    return r;
  endfunction

  function automatic logic in_window(idx_t i, int first, int last);
    return (int'(i) >= first) && (int'(i) <= last);
  endfunction
endpackage

// File: rtl/cmos_port_dec.sv
module cmos_port_dec
  import cmos_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel,
  input  logic bus_wr,
  input  logic bus_rd,
  input  idx_t wr_idx_bits,
  output idx_t cur_idx,
  output logic data_wr,
  output logic data_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cur_idx <= '0;
    else if (bus_wr && !bus_sel) cur_idx <= wr_idx_bits;
  end

  assign data_wr = bus_wr && bus_sel;
  assign data_rd = bus_rd && bus_sel;
endmodule

// File: rtl/cmos_cks_seq.sv
module cmos_cks_seq
  import cmos_pkg::*;
#(
  parameter int FIRST = 16,
  parameter int LAST  = 45
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  byte_t rd_byte,
  output idx_t  rd_idx,
  output logic  busy,
  output logic  res_we,
  output sum_t  res_val
);
  localparam idx_t START_IDX = idx_t'(FIRST);
  localparam idx_t END_IDX   = idx_t'(LAST + 1);

  logic run;
  idx_t ptr;
  sum_t acc;
  logic at_end;

  assign at_end = (ptr == END_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      ptr <= START_IDX;
      acc <= '0;
    end else if (restart) begin
      run <= 1'b1;
      ptr <= START_IDX;
      acc <= '0;
    end else if (run) begin
      if (at_end) begin
        run <= 1'b0;
      end else begin
        acc <= sum_step(acc, rd_byte);
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign rd_idx  = ptr;
  assign busy    = run;
  assign res_we  = run && at_end;
  assign res_val = acc;
endmodule

// File: rtl/cmos_store.sv
module cmos_store
  import cmos_pkg::*;
#(
  parameter int SUM_HI_IDX = 46,
  parameter int SUM_LO_IDX = 47
) (
  input  logic  clk,
  input  logic  rst_n,
  input  idx_t  cur_idx,
  input  logic  data_wr,
  input  logic  data_rd,
  input  byte_t wdata,
  input  logic  host_wr,
  input  idx_t  host_idx,
  input  byte_t host_wdata,
  input  byte_t evt_flags,
  input  logic  uip_set,
  input  logic  uip_clr,
  input  idx_t  seq_idx,
  input  logic  res_we,
  input  sum_t  res_val,
  output byte_t rd_byte,
  output byte_t seq_byte,
  output byte_t flags_q,
  output byte_t stat_q,
  output logic  busy_bit,
  output logic  irq
);
  localparam idx_t HI_IX = idx_t'(SUM_HI_IDX);
  localparam idx_t LO_IX = idx_t'(SUM_LO_IDX);

  byte_t mem [NREG];

  logic flag_rd_clr;
  logic evt_any;
  logic freeze_wr;

  assign flag_rd_clr = data_rd && (cur_idx == IX_FLAGS);
  assign evt_any     = |evt_flags;
  assign freeze_wr   = data_wr && (cur_idx == IX_CTRL_B) && wdata[FREEZE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reset_value(idx_t'(i));
    end else begin
      if (host_wr) mem[host_idx] <= host_wdata;
      if (data_wr) begin
        case (cur_idx)
          IX_CTRL_A: mem[IX_CTRL_A] <= ctrl_a_merge(mem[IX_CTRL_A], wdata);
          IX_FLAGS, IX_STAT: ;
          default:   mem[cur_idx] <= wdata;
        endcase
      end
      if (uip_clr)
        mem[IX_CTRL_A][BUSY_BIT] <= 1'b0;
      else if (uip_set && !mem[IX_CTRL_B][FREEZE_BIT])
        mem[IX_CTRL_A][BUSY_BIT] <= 1'b1;
      if (freeze_wr) mem[IX_CTRL_A][BUSY_BIT] <= 1'b0;
      if (flag_rd_clr)  mem[IX_FLAGS] <= evt_flags;
      else if (evt_any) mem[IX_FLAGS] <= mem[IX_FLAGS] | evt_flags;
      if (res_we) begin
        mem[HI_IX] <= res_val[SUM_W-1:DATA_W];
        mem[LO_IX] <= res_val[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           irq <= 1'b0;
    else if (flag_rd_clr) irq <= evt_any;
    else if (evt_any)     irq <= 1'b1;
  end

  assign rd_byte  = mem[cur_idx];
  assign seq_byte = mem[seq_idx];
  assign flags_q  = mem[IX_FLAGS];
  assign stat_q   = mem[IX_STAT];
  assign busy_bit = mem[IX_CTRL_A][BUSY_BIT];
endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
  import cmos_pkg::*;
#(
  parameter int SUM_FIRST  = 16,
  parameter int SUM_LAST   = 45,
  parameter int SUM_HI_IDX = 46,
  parameter int SUM_LO_IDX = 47
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        host_wr,
  input  logic [6:0]  host_idx,
  input  logic [7:0]  host_wdata,
  input  logic [7:0]  evt_flags,
  input  logic        uip_set,
  input  logic        uip_clr,
  output logic        irq,
  output logic        cks_busy
);
  idx_t  cur_idx;
  logic  data_wr, data_rd;
  idx_t  seq_idx;
  byte_t seq_byte, rd_byte;
  logic  res_we;
  sum_t  res_val;
  logic  cks_restart;
  byte_t flags_q, stat_q;
  logic  busy_bit;

  assign cks_restart = host_wr && in_window(host_idx, SUM_FIRST, SUM_LAST);

  cmos_port_dec u_dec (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .wr_idx_bits(bus_wdata[IDX_W-1:0]), .cur_idx(cur_idx),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  cmos_cks_seq #(.FIRST(SUM_FIRST), .LAST(SUM_LAST)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(cks_restart), .rd_byte(seq_byte),
    .rd_idx(seq_idx), .busy(cks_busy), .res_we(res_we), .res_val(res_val)
  );

  cmos_store #(.SUM_HI_IDX(SUM_HI_IDX), .SUM_LO_IDX(SUM_LO_IDX)) u_store (
    .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(bus_wdata), .host_wr(host_wr), .host_idx(host_idx), .host_wdata(host_wdata),
    .evt_flags(evt_flags), .uip_set(uip_set), .uip_clr(uip_clr),
    .seq_idx(seq_idx), .res_we(res_we), .res_val(res_val),
    .rd_byte(rd_byte), .seq_byte(seq_byte), .flags_q(flags_q), .stat_q(stat_q),
    .busy_bit(busy_bit), .irq(irq)
  );

  assign bus_rdata = bus_sel ? rd_byte : 8'hFF;
endmodule

// File: rtl/cmos_regfile_chk.sv
module cmos_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic       host_wr,
  input logic [6:0] host_idx,
  input logic [7:0] evt_flags,
  input logic       uip_set,
  input logic       uip_clr,
  input logic [6:0] cur_idx,
  input logic [7:0] flags_q,
  input logic [7:0] stat_q,
  input logic       busy_bit,
  input logic       irq,
  input logic       cks_busy
);
  logic dwr, drd;
  assign dwr = bus_wr && bus_sel;
  assign drd = bus_rd && bus_sel;

  a_r1_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> (cur_idx == $past(bus_wdata[6:0])));

  a_r3_status_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && cur_idx == 7'd13 && !host_wr) |=> $stable(stat_q));

  a_r4_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && cur_idx == 7'd10 && !uip_set && !uip_clr && !host_wr) |=> $stable(busy_bit));

  a_r6_freeze_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && cur_idx == 7'd11 && bus_wdata[7]) |=> !busy_bit);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && cur_idx == 7'd12 && evt_flags == 8'h00) |=> (flags_q == 8'h00 && !irq));

  a_r10_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flags != 8'h00) |=> irq);

  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(drd && cur_idx == 7'd12)) |=> irq);

  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_idx >= 7'h10 && host_idx <= 7'h2D) |=> cks_busy);

  a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (uip_clr) |=> !busy_bit);
endmodule

bind cmos_regfile cmos_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .host_wr(host_wr), .host_idx(host_idx), .evt_flags(evt_flags),
  .uip_set(uip_set), .uip_clr(uip_clr), .cur_idx(cur_idx), .flags_q(flags_q),
  .stat_q(stat_q), .busy_bit(busy_bit), .irq(irq), .cks_busy(cks_busy)
);

// File: tb/cmos_regfile_test.sv
`timescale 1ns/1ps
module cmos_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       host_wr = 1'b0;
  logic [6:0] host_idx = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] evt_flags = '0;
  logic       uip_set = 1'b0, uip_clr = 1'b0;
  logic       irq, cks_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] mdl [128];

  always #2 clk = ~clk;

  cmos_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_wr(host_wr), .host_idx(host_idx),
    .host_wdata(host_wdata), .evt_flags(evt_flags), .uip_set(uip_set), .uip_clr(uip_clr),
    .irq(irq), .cks_busy(cks_busy)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input logic sel, output logic [7:0] v);
    @(negedge clk); bus_sel = sel; bus_rd = 1'b1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_idx(input logic [6:0] i, output logic [7:0] v);
    bwrite(1'b0, {1'b0, i});
    bread(1'b1, v);
  endtask

  task automatic wr_idx(input logic [6:0] i, input logic [7:0] d);
    bwrite(1'b0, {1'b0, i});
    bwrite(1'b1, d);
  endtask

  task automatic hwrite(input logic [6:0] i, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_idx = i; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (cks_busy && n < 200) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v, hi, lo;
    logic [15:0] sum;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset values, R2 index location reads 0xFF
    bus_sel = 1'b1; #1 check("R1 R9 index0 byte", {8'h0, bus_rdata}, 16'h0000);
    bus_sel = 1'b0; #1 check("R2 even read", {8'h0, bus_rdata}, 16'h00FF);
    check("R9 irq", {15'h0, irq}, 16'h0); check("R9 busy", {15'h0, cks_busy}, 16'h0);
    rd_idx(7'd10, v); check("R9 idx10", {8'h0, v}, 16'h0026);
    rd_idx(7'd11, v); check("R9 idx11", {8'h0, v}, 16'h0002);
    rd_idx(7'd12, v); check("R9 idx12", {8'h0, v}, 16'h0000);
    rd_idx(7'd13, v); check("R9 idx13", {8'h0, v}, 16'h0080);

    // R11 fill, R1 sweep of all 256 index bytes
    for (int i = 0; i < 128; i++) begin
      mdl[i] = 8'((i * 37 + 5) & 255);
      if (i >= 10 && i <= 13) mdl[i] = (i == 10) ? 8'h26 : (i == 11) ? 8'h02 : (i == 12) ? 8'h00 : 8'h80;
      else wr_idx(7'(i), mdl[i]);
    end
    check("R8 port write no busy", {15'h0, cks_busy}, 16'h0);
    for (int d = 0; d < 256; d++) begin
      bwrite(1'b0, 8'(d));
      bread(1'b1, v);
      check("R1 R11 sweep", {8'h0, v}, {8'h0, mdl[d & 127]});
    end

    // R3 ignored writes
    wr_idx(7'd13, 8'h11); rd_idx(7'd13, v); check("R3 status write", {8'h0, v}, 16'h0080);
    @(negedge clk); evt_flags = 8'h40; @(negedge clk); evt_flags = 8'h00;
    check("R10 irq raised", {15'h0, irq}, 16'h1);
    wr_idx(7'd12, 8'h00);
    check("R10 irq held", {15'h0, irq}, 16'h1);
    rd_idx(7'd12, v); check("R3 R5 flags value", {8'h0, v}, 16'h0040);
    check("R5 irq dropped", {15'h0, irq}, 16'h0);
    bread(1'b1, v); check("R5 flags cleared", {8'h0, v}, 16'h0000);
    // R5 event during clearing read survives
    @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1; evt_flags = 8'h21; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; evt_flags = 8'h00;
    check("R5 read before event", {8'h0, v}, 16'h0000);
    check("R5 irq kept by event", {15'h0, irq}, 16'h1);
    bread(1'b1, v); check("R5 event kept", {8'h0, v}, 16'h0021);

    // R4 / R12 busy bit
    @(negedge clk); uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
    wr_idx(7'd10, 8'h05); rd_idx(7'd10, v); check("R4 R12 keep busy 1", {8'h0, v}, 16'h0085);
    @(negedge clk); uip_set = 1'b1; uip_clr = 1'b1; @(negedge clk); uip_set = 1'b0; uip_clr = 1'b0;
    bread(1'b1, v); check("R12 clear wins", {8'h0, v}, 16'h0005);
    wr_idx(7'd10, 8'hFF); rd_idx(7'd10, v); check("R4 keep busy 0", {8'h0, v}, 16'h007F);
    // R6 freeze
    @(negedge clk); uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
    wr_idx(7'd11, 8'h82); rd_idx(7'd10, v); check("R6 freeze clears busy", {8'h0, v}, 16'h007F);
    @(negedge clk); uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
    bread(1'b1, v); check("R6 set ignored in freeze", {8'h0, v}, 16'h007F);
    wr_idx(7'd11, 8'h02);
    @(negedge clk); uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
    rd_idx(7'd10, v); check("R6 R12 set after freeze", {8'h0, v}, 16'h00FF);

    // R7 / R8 checksum patterns
    for (int k = 0; k < 3; k++) begin
      sum = '0;
      for (int i = 16; i <= 45; i++) begin
        v = (k == 0) ? 8'hFF : (k == 1) ? 8'(i ^ 8'h5A) : 8'h00;
        mdl[i] = v; sum = sum + 16'(v);
        hwrite(7'(i), v);
      end
      busy_len(n);
      check("R8 busy length", 16'(n), 16'd31);
      rd_idx(7'h2E, hi); rd_idx(7'h2F, lo);
      check("R7 checksum", {hi, lo}, sum);
    end
    // R8 restart
    hwrite(7'h20, 8'hA0); mdl[32] = 8'hA0;
    repeat (5) @(negedge clk);
    hwrite(7'h2D, 8'h77); mdl[45] = 8'h77;
    busy_len(n); check("R8 restart length", 16'(n), 16'd31);
    sum = '0; for (int i = 16; i <= 45; i++) sum = sum + 16'(mdl[i]);
    rd_idx(7'h2E, hi); rd_idx(7'h2F, lo); check("R7 after restart", {hi, lo}, sum);
    // R8 window edges and non-triggers
    hwrite(7'h0F, 8'h33); check("R8 below window", {15'h0, cks_busy}, 16'h0);
    hwrite(7'h2E, 8'h33); check("R8 above window", {15'h0, cks_busy}, 16'h0);
    rd_idx(7'h2E, v); check("R11 host raw write", {8'h0, v}, 16'h0033);
    wr_idx(7'h15, 8'h99); check("R8 port write in window", {15'h0, cks_busy}, 16'h0);
    hwrite(7'h10, mdl[16]); mdl[21] = 8'h99;
    busy_len(n); check("R8 low edge length", 16'(n), 16'd31);
    sum = '0; for (int i = 16; i <= 45; i++) sum = sum + 16'(mdl[i]);
    rd_idx(7'h2E, hi); rd_idx(7'h2F, lo); check("R7 includes port byte", {hi, lo}, sum);

    finish_run();
  end
endmodule